// File: doc/BRIEF.md
# Wavefront Control-Flow Issue Engine

This block steps a set of wavefronts through their control-flow instruction streams inside one compute unit. Ready wavefronts wait in an internal FIFO of wavefront IDs. Each cycle the fetch stage may take the head wavefront out of that FIFO and read its next instruction word from an external instruction memory. The word goes into a one-entry buffer owned by that wavefront. A decode stage then turns filled byte buffers into decoded entries, again held one per wavefront. An execute stage handles one decoded entry per cycle. It can finish a local control-flow operation, hand a secondary ALU or fetch clause to another engine through a valid/ready request, or end the wavefront's program. A complete stage puts finished wavefronts back into the FIFO.

A wavefront is out of the ready FIFO from fetch until complete. If it launched a clause, it stays parked until the clause-done signal for its ID arrives. Decode, execute and complete each choose among the wavefronts that have work, in round-robin order. Their pointers move only when a choice is accepted. A dispatcher brings new wavefronts in through an insert port. The meaning of individual control-flow operations is outside this block.

Top module: `cfe_engine`

## Requirements
- R1: After reset the engine holds no wavefront. `imem_rd_en`, `clause_req_valid` and `retire_valid` are low and `add_ready` is high.
- R2: An insert is taken on a cycle with `add_valid` and `add_ready` both high. `add_ready` is low in any cycle where the complete stage returns a wavefront to the ready FIFO, and when the FIFO is full.
- R3: The instruction word carries an operation class in bits [1:0]: 0 local, 1 ALU clause, 2 fetch clause, 3 end of program. A clause request carries bits [IW-1:2] unchanged on `clause_req_arg`. `clause_req_kind` is 0 for ALU and 1 for fetch.
- R4: Fetch takes the FIFO head. It drives `imem_addr` = {wavefront ID, program counter}. The program counter restarts at 0 when the wavefront is inserted and advances by one on each fetch of that wavefront.
- R5: A lone wavefront running a local operation is fetched again exactly 4 cycles after the previous fetch, and it is never fetched in two consecutive cycles.
- R6: A clause request stays valid, with its ID, class and argument stable, until `clause_req_ready`. The wavefront then waits for `clause_done_valid` with its ID. If done arrives D≥1 cycles after acceptance, the gap between fetches is 4+D cycles.
- R7: An end-of-program operation pulses `retire_valid` with the wavefront's ID in the cycle after it is decoded, and the wavefront does not return to the FIFO. A program that is only that operation retires in the second cycle after insertion.
- R8: Execute grants the first wavefront with a decoded entry at or after its pointer. The pointer moves to the slot after an accepted grant. A stalled clause request keeps its wavefront until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| add_valid | input | 1 | Insert a wavefront into the ready FIFO |
| add_wf | input | WIDW | ID of the inserted wavefront |
| add_ready | output | 1 | Insert can be taken this cycle |
| imem_rd_en | output | 1 | Fetch reads instruction memory this cycle |
| imem_addr | output | WIDW+PCW | {wavefront ID, program counter} |
| imem_rdata | input | IW | Instruction word, same-cycle read data |
| clause_req_valid | output | 1 | Secondary clause launch request |
| clause_req_ready | input | 1 | Clause engine accepts the request |
| clause_req_kind | output | 1 | 0 ALU clause, 1 fetch clause |
| clause_req_wf | output | WIDW | Requesting wavefront |
| clause_req_arg | output | IW-2 | Argument field of the instruction |
| clause_done_valid | input | 1 | A launched clause has finished |
| clause_done_wf | input | WIDW | Wavefront whose clause finished |
| retire_valid | output | 1 | A wavefront reached end of program |
| retire_wf | output | WIDW | Retiring wavefront |

## Verification
Insertion-to-retire latency is measured for programs that mix local, ALU and fetch operations under different clause delays. A design that adds or drops a stage, or returns a wavefront before its clause is done, gives the wrong cycle count. Four wavefronts are piled up behind a clause port that is held not ready. The bench then checks that the first requester is kept and that the rest are served in pointer order, not arrival order, so an arbiter that re-chooses while stalled or resets its pointer is caught. The instruction address and the collision between insert and complete are sampled in the exact cycles where the program counter or `add_ready` must change.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
   typedef enum logic [1:0] {
      K_LOCAL = 2'd0,
      K_ALU   = 2'd1,
      K_TEX   = 2'd2,
      K_END   = 2'd3
   } cf_kind_e;

   typedef enum logic [2:0] {
      S_OFF   = 3'd0,
      S_POOL  = 3'd1,
      S_BYTES = 3'd2,
      S_INSTR = 3'd3,
      S_WAIT  = 3'd4,
      S_DONE  = 3'd5
   } wf_state_e;
endpackage

// File: rtl/cfe_ready_pool.sv
module cfe_ready_pool #(
   parameter int DEPTH = 4,
   parameter int IDW   = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           push,
   input  logic [IDW-1:0] push_id,
   input  logic           pop,
   output logic [IDW-1:0] head_id,
   output logic           empty,
   output logic           full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [IDW-1:0] slot_q [DEPTH];
   logic [PW-1:0]  wr_q, rd_q, wr_nx, rd_nx;
   logic [CW-1:0]  cnt_q;

   generate
      if ((1 << PW) == DEPTH) begin : g_pow2
         assign wr_nx = wr_q + 1'b1;
         assign rd_nx = rd_q + 1'b1;
      end else begin : g_wrap
         assign wr_nx = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
         assign rd_nx = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) slot_q[wr_q] <= push_id;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wr_q <= wr_nx;
         if (pop)  rd_q <= rd_nx;
         if (push && !pop)      cnt_q <= cnt_q + 1'b1;
         else if (pop && !push) cnt_q <= cnt_q - 1'b1;
      end
   end

   assign head_id = slot_q[rd_q];
   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CW'(DEPTH));

   a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/cfe_rr_arb.sv
module cfe_rr_arb #(
   parameter int  N  = 4,
   localparam int XW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   input  logic          adv,
   input  logic [XW-1:0] adv_idx,
   output logic          any,
   output logic [XW-1:0] gnt_idx
);
   logic [XW-1:0] ptr_q;

   always_comb begin
      int idx;
      any     = 1'b0;
      gnt_idx = '0;
      for (int k = 0; k < N; k++) begin
         idx = int'(ptr_q) + k;
         if (idx >= N) idx = idx - N;
         if (!any && req[idx]) begin
            any     = 1'b1;
            gnt_idx = XW'(idx);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   ptr_q <= '0;
      else if (adv) ptr_q <= (adv_idx == XW'(N - 1)) ? '0 : adv_idx + 1'b1;
   end

   a_r8_adv_requested: assert property (@(posedge clk) disable iff (!rst_n)
      adv |-> req[adv_idx]);
endmodule

// File: rtl/cfe_engine.sv
module cfe_engine
   import cfe_pkg::*;
#(
   parameter int  NWF        = 4,
   parameter int  POOL_DEPTH = 4,
   parameter int  PCW        = 4,
   parameter int  IW         = 16,
   localparam int WIDW       = $clog2(NWF),
   localparam int AW         = IW - 2,
   localparam int IAW        = WIDW + PCW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            add_valid,
   input  logic [WIDW-1:0] add_wf,
   output logic            add_ready,
   output logic            imem_rd_en,
   output logic [IAW-1:0]  imem_addr,
   input  logic [IW-1:0]   imem_rdata,
   output logic            clause_req_valid,
   input  logic            clause_req_ready,
   output logic            clause_req_kind,
   output logic [WIDW-1:0] clause_req_wf,
   output logic [AW-1:0]   clause_req_arg,
   input  logic            clause_done_valid,
   input  logic [WIDW-1:0] clause_done_wf,
   output logic            retire_valid,
   output logic [WIDW-1:0] retire_wf
);
   generate
      if (NWF < 2) begin : g_bad_nwf
         $error("cfe_engine: NWF must be at least 2");
      end
      if (POOL_DEPTH < NWF) begin : g_bad_depth
         $error("cfe_engine: POOL_DEPTH must hold every wavefront");
      end
      if (IW < 3) begin : g_bad_iw
         $error("cfe_engine: IW must leave room for an argument");
      end
   endgenerate

   wf_state_e       st_q [NWF];
   logic [PCW-1:0]  pc_q [NWF];
   logic [IW-1:0]   bb_q [NWF];
   cf_kind_e        ik_q [NWF];
   logic [AW-1:0]   ia_q [NWF];

   logic [NWF-1:0]  dreq, ereq, creq;
   logic            pool_push, pool_empty, pool_full, fetch_go;
   logic [WIDW-1:0] pool_push_id, head;
   logic            dany, eany, cany;
   logic [WIDW-1:0] didx, eidx, cidx, sel;
   logic            hold_q, ex_valid, ex_fire, is_clause, add_fire;
   logic [WIDW-1:0] hold_wf_q;
   cf_kind_e        sel_kind;

   generate
      for (genvar g = 0; g < NWF; g++) begin : g_req
         assign dreq[g] = (st_q[g] == S_BYTES);
         assign ereq[g] = (st_q[g] == S_INSTR);
         assign creq[g] = (st_q[g] == S_DONE);
      end
   endgenerate

   // ready FIFO: complete stage has priority over the insert port
   assign add_ready    = !cany && !pool_full;
   assign add_fire     = add_valid && add_ready;
   assign pool_push    = cany || add_fire;
   assign pool_push_id = cany ? cidx : add_wf;
   assign fetch_go     = !pool_empty && (st_q[head] == S_POOL);

   cfe_ready_pool #(.DEPTH(POOL_DEPTH), .IDW(WIDW)) u_pool (
      .clk(clk), .rst_n(rst_n), .push(pool_push), .push_id(pool_push_id),
      .pop(fetch_go), .head_id(head), .empty(pool_empty), .full(pool_full));

   cfe_rr_arb #(.N(NWF)) u_dec_arb (
      .clk(clk), .rst_n(rst_n), .req(dreq), .adv(dany), .adv_idx(didx),
      .any(dany), .gnt_idx(didx));

   cfe_rr_arb #(.N(NWF)) u_exe_arb (
      .clk(clk), .rst_n(rst_n), .req(ereq), .adv(ex_fire), .adv_idx(sel),
      .any(eany), .gnt_idx(eidx));

   cfe_rr_arb #(.N(NWF)) u_cmp_arb (
      .clk(clk), .rst_n(rst_n), .req(creq), .adv(cany), .adv_idx(cidx),
      .any(cany), .gnt_idx(cidx));

   // execute: a stalled clause request keeps its wavefront
   assign sel       = hold_q ? hold_wf_q : eidx;
   assign ex_valid  = hold_q || eany;
   assign sel_kind  = ik_q[sel];
   assign is_clause = (sel_kind == K_ALU) || (sel_kind == K_TEX);
   assign ex_fire   = ex_valid && (!is_clause || clause_req_ready);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q    <= 1'b0;
         hold_wf_q <= '0;
      end else begin
         hold_q    <= clause_req_valid && !clause_req_ready;
         hold_wf_q <= sel;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NWF; i++) begin
            st_q[i] <= S_OFF;
            pc_q[i] <= '0;
            bb_q[i] <= '0;
            ik_q[i] <= K_LOCAL;
            ia_q[i] <= '0;
         end
      end else begin
         for (int i = 0; i < NWF; i++) begin
            if (add_fire && add_wf == WIDW'(i)) begin
               st_q[i] <= S_POOL;
               pc_q[i] <= '0;
            end else begin
               case (st_q[i])
                  S_POOL: if (fetch_go && head == WIDW'(i)) begin
                     st_q[i] <= S_BYTES;
                     bb_q[i] <= imem_rdata;
                     pc_q[i] <= pc_q[i] + 1'b1;
                  end
                  S_BYTES: if (dany && didx == WIDW'(i)) begin
                     st_q[i] <= S_INSTR;
                     ik_q[i] <= cf_kind_e'(bb_q[i][1:0]);
                     ia_q[i] <= bb_q[i][IW-1:2];
                  end
                  S_INSTR: if (ex_fire && sel == WIDW'(i)) begin
                     case (ik_q[i])
                        K_LOCAL: st_q[i] <= S_DONE;
                        K_END:   st_q[i] <= S_OFF;
                        default: st_q[i] <= S_WAIT;
                     endcase
                  end
                  S_WAIT: if (clause_done_valid && clause_done_wf == WIDW'(i))
                     st_q[i] <= S_DONE;
                  S_DONE: if (cany && cidx == WIDW'(i))
                     st_q[i] <= S_POOL;
                  default: ;
               endcase
            end
         end
      end
   end

   assign imem_rd_en       = fetch_go;
   assign imem_addr        = {head, pc_q[head]};
   assign clause_req_valid = ex_valid && is_clause;
   assign clause_req_kind  = (sel_kind == K_TEX);
   assign clause_req_wf    = sel;
   assign clause_req_arg   = ia_q[sel];
   assign retire_valid     = ex_fire && (sel_kind == K_END);
   assign retire_wf        = sel;

   a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      clause_req_valid && !clause_req_ready |=> clause_req_valid
      && $stable(clause_req_wf) && $stable(clause_req_kind) && $stable(clause_req_arg));
   a_r5_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
      imem_rd_en |=> !(imem_rd_en && imem_addr[IAW-1:PCW] == $past(imem_addr[IAW-1:PCW])));
   a_r7_retire_leaves: assert property (@(posedge clk) disable iff (!rst_n)
      retire_valid |=> st_q[$past(retire_wf)] == S_OFF);
   a_r2_add_idle: assert property (@(posedge clk) disable iff (!rst_n)
      add_valid && add_ready |-> st_q[add_wf] == S_OFF);
   a_r6_done_waiting: assert property (@(posedge clk) disable iff (!rst_n)
      clause_done_valid |-> st_q[clause_done_wf] == S_WAIT);
endmodule

// File: tb/sim_cfe_engine.sv
`timescale 1ns/1ps
module sim_cfe_engine;
   localparam int NWF = 4, PCW = 4, IW = 16;
   localparam int WIDW = 2, AW = IW - 2;
   // {prog k3,k2,k1,k0}[23:16], clause delay [15:12], latency [11:4], clause count [3:0]
   localparam logic [23:0] VEC [6] = '{
      {8'hFF, 4'd1, 8'd2,  4'd0},
      {8'hFC, 4'd1, 8'd6,  4'd0},
      {8'hC0, 4'd1, 8'd14, 4'd0},
      {8'hFD, 4'd1, 8'd7,  4'd1},
      {8'hF2, 4'd3, 8'd13, 4'd1},
      {8'hD9, 4'd2, 8'd20, 4'd3}
   };

   logic clk = 0, rst_n = 0;
   logic add_valid = 0, add_ready;
   logic [WIDW-1:0] add_wf = '0;
   logic imem_rd_en;
   logic [WIDW+PCW-1:0] imem_addr;
   logic [IW-1:0] imem_rdata;
   logic clause_req_valid, clause_req_ready = 1, clause_req_kind;
   logic [WIDW-1:0] clause_req_wf, retire_wf;
   logic [AW-1:0] clause_req_arg;
   logic clause_done_valid = 0;
   logic [WIDW-1:0] clause_done_wf = '0;
   logic retire_valid;

   logic [1:0] prog [NWF][16];
   int checks = 0, failures = 0, dly = 1, nacc = 0, nret = 0, cyc_n = 0, tick = 0;
   logic [WIDW-1:0] qwf [16];
   int qdue [16];
   int qh = 0, qt = 0;
   logic [WIDW-1:0] order [8];
   bit fin = 0;

   always #10 clk = ~clk;

   cfe_engine u0 (.*);

   always_comb imem_rdata = {10'd0, imem_addr[PCW-1:0], prog[imem_addr[WIDW+PCW-1:PCW]][imem_addr[PCW-1:0]]};

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // clause responder and retire counter, at the falling edge
   always @(negedge clk) begin
      cyc_n++;
      clause_done_valid = 0;
      if (qh != qt && qdue[qh] <= cyc_n) begin
         clause_done_valid = 1;
         clause_done_wf = qwf[qh];
         qh = (qh + 1) % 16;
      end
      if (rst_n && clause_req_valid && clause_req_ready) begin
         // R3: class and argument carried into the request
         check(int'(clause_req_kind) == ((prog[clause_req_wf][clause_req_arg[3:0]] == 2'd2) ? 1 : 0),
               "R3 clause kind", int'(clause_req_kind), int'(prog[clause_req_wf][clause_req_arg[3:0]]));
         qwf[qt] = clause_req_wf;
         qdue[qt] = cyc_n + dly;
         qt = (qt + 1) % 16;
         if (nacc < 8) order[nacc] = clause_req_wf;
         nacc++;
      end
      if (rst_n && retire_valid) nret++;
   end

   always @(posedge clk) begin
      tick++;
      if (tick > 20000 && !fin) begin
         failures++;
         $display("FAIL R5 watchdog actual=%0d expected=done", tick);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic load(input int w, input logic [7:0] p);
      for (int k = 0; k < 16; k++) prog[w][k] = (k < 4) ? p[2*k +: 2] : 2'd3;
   endtask

   task automatic add(input int w);
      @(negedge clk);
      add_valid = 1;
      add_wf = WIDW'(w);
      @(posedge clk);
      @(negedge clk);
      add_valid = 0;
   endtask

   initial begin
      for (int w = 0; w < NWF; w++) load(w, 8'hFF);
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check(add_ready == 1, "R1 add_ready", add_ready, 1);
      check(imem_rd_en == 0, "R1 imem_rd_en", imem_rd_en, 0);
      check(clause_req_valid == 0, "R1 clause_req_valid", clause_req_valid, 0);
      check(retire_valid == 0, "R1 retire_valid", retire_valid, 0);
      rst_n = 1;
      @(negedge clk);

      // vector table: insertion-to-retire latency on wavefront 0
      for (int v = 0; v < 6; v++) begin
         int n;
         bit seen;
         string tag;
         load(0, VEC[v][23:16]);
         dly = int'(VEC[v][15:12]);
         nacc = 0;
         tag = (VEC[v][3:0] != 0) ? "R6" : ((VEC[v][23:16] == 8'hFF) ? "R7" : "R5");
         @(negedge clk);
         add_valid = 1;
         add_wf = 0;
         @(posedge clk);
         @(negedge clk);
         add_valid = 0;
         n = 0;
         seen = 0;
         while (!seen && n < 100) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (retire_valid) begin
               seen = 1;
               check(retire_wf == 0, "R7 retire_wf", retire_wf, 0);
            end
         end
         check(n == int'(VEC[v][11:4]), {tag, " latency"}, n, int'(VEC[v][11:4]));
         check(nacc == int'(VEC[v][3:0]), "R6 clause count", nacc, int'(VEC[v][3:0]));
         repeat (4) @(negedge clk);
      end

      // R4 / R2: fetch address and insert yielding to complete
      load(2, 8'hFC);
      @(negedge clk);
      add_valid = 1;
      add_wf = 2;
      @(posedge clk);
      @(negedge clk);
      add_valid = 0;
      check(imem_rd_en == 1 && imem_addr == 6'h20, "R4 first fetch addr", int'(imem_addr), 32);
      @(negedge clk);
      @(negedge clk);
      check(add_ready == 1, "R2 add_ready before complete", add_ready, 1);
      @(negedge clk);
      check(add_ready == 0, "R2 add_ready during complete", add_ready, 0);
      @(negedge clk);
      check(imem_rd_en == 1 && imem_addr == 6'h21, "R4 second fetch addr", int'(imem_addr), 33);
      @(negedge clk);
      @(negedge clk);
      check(retire_valid == 1 && retire_wf == 2, "R7 retire wf2", int'(retire_wf), 2);
      repeat (4) @(negedge clk);

      // R8: stalled request keeps its wavefront, then round-robin order
      for (int w = 0; w < NWF; w++) load(w, 8'hFD);
      dly = 1;
      nacc = 0;
      nret = 0;
      clause_req_ready = 0;
      add(3);
      add(1);
      add(2);
      add(0);
      repeat (6) @(negedge clk);
      check(clause_req_valid == 1 && clause_req_wf == 3, "R8 locked request", int'(clause_req_wf), 3);
      clause_req_ready = 1;
      for (int k = 0; k < 60 && nret < 4; k++) @(negedge clk);
      check(nacc == 4, "R8 accepted count", nacc, 4);
      check(nret == 4, "R7 retire count", nret, 4);
      check(order[0] == 3, "R8 order 0", int'(order[0]), 3);
      check(order[1] == 0, "R8 order 1", int'(order[1]), 0);
      check(order[2] == 1, "R8 order 2", int'(order[2]), 1);
      check(order[3] == 2, "R8 order 3", int'(order[3]), 2);

      fin = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule